// File: doc/BRIEF.md
# Shadow Doorbell Setup Unit

This unit services the admin command that tells a storage queue controller where the host keeps its shadow doorbell values and its event-index values. The command arrives already decoded as an opcode strobe with two 64-bit base addresses. The first pointer carries the shadow doorbell base and the second carries the event-index base. The unit checks that both bases sit on a memory page boundary and answers one cycle later with a completion status. When the check passes, it keeps both bases and turns on a global enable.

Queue engines then present a queue identifier on a lookup port. For that queue the unit returns four addresses: the shadow doorbell slot and the event-index slot for the submission queue, and the same two slots for the completion queue. The slots are spaced by the runtime doorbell stride. The admin queue, identifier zero, never gets shadow addresses and keeps using its register doorbells. A controller reset withdraws the whole configuration. The unit also drives a constant capability word for the identify data. Bit 8 of that word advertises the feature.

Top module: `shadow_db_setup`

## Requirements
- R1: A command with opcode 0x7C that is sampled on a clock edge while `ctrl_reset` is low raises `rsp_valid` for exactly one cycle after that edge. Any other opcode produces no response and changes no state.
- R2: The command succeeds, with `rsp_status` = 0x0000, when both bases have their low `page_shift` bits all zero. Page size is 2^`page_shift` bytes.
- R3: If either base has a nonzero bit below the page size, `rsp_status` is 0x4002. This is generic invalid-field code 0x02 in bits 7:0 with the do-not-retry flag in bit 14. The enable, the bases and all lookup outputs keep their previous values.
- R4: A successful command stores both bases and sets `shadow_enabled`. A later successful command replaces the stored bases.
- R5: The doorbell stride is 4 << `stride_field` bytes. For queue Q, each submission slot address is the stored base + 2·Q·stride. This applies to both the doorbell buffer and the event-index buffer.
- R6: For queue Q, each completion slot address is the stored base + (2·Q+1)·stride, in both buffers.
- R7: For `lk_qid` = 0, `lk_valid` is low and all four address outputs are zero.
- R8: While the unit is not enabled, `lk_valid` is low and all four address outputs are zero for any queue.
- R9: `ctrl_reset` high at a clock edge clears both bases and the enable. A command sampled on that same edge is dropped and gets no response.
- R10: `oacs_caps` is always 0x0100, with only bit 8 set.
- R11: `rst_n` low at a clock edge clears the bases, the enable and `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_reset | input | 1 | Synchronous controller reset, clears the configuration |
| cmd_valid | input | 1 | Decoded admin command strobe |
| cmd_opcode | input | 8 | Admin opcode |
| cmd_ptr0 | input | 64 | Shadow doorbell base (first data pointer) |
| cmd_ptr1 | input | 64 | Event-index base (second data pointer) |
| page_shift | input | 6 | log2 of the memory page size in bytes |
| stride_field | input | 4 | Doorbell stride field from the capability register |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_status | output | 16 | Completion status |
| shadow_enabled | output | 1 | Shadow doorbells configured |
| oacs_caps | output | 16 | Optional admin command support bits |
| lk_qid | input | 16 | Queue identifier to look up |
| lk_valid | output | 1 | Lookup addresses are meaningful |
| sq_db_addr | output | 64 | Submission queue shadow doorbell slot |
| sq_ei_addr | output | 64 | Submission queue event-index slot |
| cq_db_addr | output | 64 | Completion queue shadow doorbell slot |
| cq_ei_addr | output | 64 | Completion queue event-index slot |

## Verification
The assertions assume that `stride_field`, `page_shift` and `lk_qid` are stable across the cycle in which a result is compared. They also assume that `page_shift` stays below 64, so the alignment mask is well formed. The assertions on slot spacing further assume that the chosen bases and queue numbers do not wrap the 64-bit address space. The stimulus changes inputs only on falling edges and uses page shifts of 12 and 16. Its bases and queue numbers keep every slot address far below 2^64, even at the largest stride and queue number exercised.

// File: rtl/shadow_db_pkg.sv
// Shared constants for the shadow doorbell setup unit.
// Assumes an admin status word of 16 bits and an 8-bit opcode.
package shadow_db_pkg;
    localparam logic [7:0]  OPC_SHADOW_CFG = 8'h7C;
    localparam logic [15:0] STS_OK         = 16'h0000;
    localparam logic [15:0] STS_BAD_FIELD  = 16'h4002;  // do-not-retry | invalid field
    localparam int          CAP_W          = 16;
    localparam int          CAP_BIT        = 8;
endpackage

// File: rtl/sdb_align_check.sv
// Page alignment check for two base addresses.
// Raises misaligned when either address has a set bit below 2^page_shift.
// Assumes page_shift is smaller than ADDR_W.
module sdb_align_check #(
    parameter int ADDR_W  = 64,
    parameter int SHIFT_W = 6
) (
    input  logic [ADDR_W-1:0]  addr_a,
    input  logic [ADDR_W-1:0]  addr_b,
    input  logic [SHIFT_W-1:0] page_shift,
    output logic               misaligned
);
    logic [ADDR_W-1:0] low_mask;

    // Build the below-page mask and test both addresses against it.
    always_comb begin
        low_mask   = ~({ADDR_W{1'b1}} << page_shift);
        misaligned = |((addr_a | addr_b) & low_mask);
    end
endmodule

// File: rtl/sdb_state_regs.sv
// Configuration state and completion response of the shadow doorbell unit.
// Accepts the setup opcode, latches both bases on success, and answers with a
// registered one-cycle status strobe. Controller reset wins over a command.
module sdb_state_regs
    import shadow_db_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_reset,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_opcode,
    input  logic [ADDR_W-1:0] cmd_ptr0,
    input  logic [ADDR_W-1:0] cmd_ptr1,
    input  logic              misaligned,
    output logic [ADDR_W-1:0] db_base,
    output logic [ADDR_W-1:0] ei_base,
    output logic              enabled,
    output logic              rsp_valid,
    output logic [15:0]       rsp_status
);
    logic accept;

    // Decide whether this cycle carries a setup command that will be served.
    always_comb accept = cmd_valid && (cmd_opcode == OPC_SHADOW_CFG) && !ctrl_reset;

    // Update configuration, enable and the response strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_base    <= '0;
            ei_base    <= '0;
            enabled    <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_status <= STS_OK;
        end else if (ctrl_reset) begin
            db_base   <= '0;
            ei_base   <= '0;
            enabled   <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                if (misaligned) begin
                    rsp_status <= STS_BAD_FIELD;
                end else begin
                    rsp_status <= STS_OK;
                    db_base    <= cmd_ptr0;
                    ei_base    <= cmd_ptr1;
                    enabled    <= 1'b1;
                end
            end
        end
    end

    // R1: a response only follows a served setup command
    assert_rsp_follows_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid && cmd_opcode == OPC_SHADOW_CFG && !ctrl_reset));

    // R3: a rejected command leaves the configuration untouched
    assert_reject_keeps_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != STS_OK) |-> ($stable(db_base) && $stable(ei_base) && $stable(enabled)));

    // R9: controller reset leaves the unit disabled with no response
    assert_ctrl_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_reset) |-> (!enabled && !rsp_valid && db_base == '0 && ei_base == '0));

    // R4: the enable only rises together with a success response
    assert_enable_on_success_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enabled) |-> (rsp_valid && rsp_status == STS_OK));
endmodule

// File: rtl/sdb_slot_calc.sv
// Per-queue slot address generator for one shadow buffer.
// Submission slot = base + 2*Q*stride, completion slot = base + (2*Q+1)*stride,
// with stride = 4 << stride_field, realised with shifts instead of multipliers.
module sdb_slot_calc #(
    parameter int ADDR_W = 64,
    parameter int QID_W  = 16,
    parameter int SF_W   = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [QID_W-1:0]  qid,
    input  logic [SF_W-1:0]   stride_field,
    output logic [ADDR_W-1:0] sq_addr,
    output logic [ADDR_W-1:0] cq_addr
);
    localparam int SH_W = SF_W + 2;

    logic [ADDR_W-1:0] q_ext;
    logic [ADDR_W-1:0] sq_off;
    logic [ADDR_W-1:0] cq_off;
    logic [SH_W-1:0]   sh_stride;

    // Shift the slot index by log2 of the stride in bytes.
    always_comb begin
        sh_stride = SH_W'(stride_field) + SH_W'(2);
        q_ext     = ADDR_W'(qid);
        sq_off    = (q_ext << 1) << sh_stride;
        cq_off    = ((q_ext << 1) | ADDR_W'(1)) << sh_stride;
        sq_addr   = base + sq_off;
        cq_addr   = base + cq_off;
    end
endmodule

// File: rtl/shadow_db_setup.sv
// Shadow doorbell setup unit (top).
// Validates the setup admin command, holds the shadow doorbell and event-index
// bases, and produces per-queue slot addresses for I/O queues. The admin queue
// (identifier 0) is never given shadow addresses. Lookup is combinational on
// the stored state; the response is registered.
module shadow_db_setup
    import shadow_db_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int QID_W   = 16,
    parameter int SF_W    = 4,
    parameter int SHIFT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_reset,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_opcode,
    input  logic [ADDR_W-1:0]  cmd_ptr0,
    input  logic [ADDR_W-1:0]  cmd_ptr1,
    input  logic [SHIFT_W-1:0] page_shift,
    input  logic [SF_W-1:0]    stride_field,
    output logic               rsp_valid,
    output logic [15:0]        rsp_status,
    output logic               shadow_enabled,
    output logic [CAP_W-1:0]   oacs_caps,
    input  logic [QID_W-1:0]   lk_qid,
    output logic               lk_valid,
    output logic [ADDR_W-1:0]  sq_db_addr,
    output logic [ADDR_W-1:0]  sq_ei_addr,
    output logic [ADDR_W-1:0]  cq_db_addr,
    output logic [ADDR_W-1:0]  cq_ei_addr
);
    localparam int NBUF = 2;  // 0: shadow doorbell, 1: event index

    logic              misaligned;
    logic [ADDR_W-1:0] db_base;
    logic [ADDR_W-1:0] ei_base;
    logic [ADDR_W-1:0] buf_base [NBUF];
    logic [ADDR_W-1:0] raw_sq   [NBUF];
    logic [ADDR_W-1:0] raw_cq   [NBUF];

    sdb_align_check #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_align (
        .addr_a     (cmd_ptr0),
        .addr_b     (cmd_ptr1),
        .page_shift (page_shift),
        .misaligned (misaligned)
    );

    sdb_state_regs #(.ADDR_W(ADDR_W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_reset (ctrl_reset),
        .cmd_valid  (cmd_valid),
        .cmd_opcode (cmd_opcode),
        .cmd_ptr0   (cmd_ptr0),
        .cmd_ptr1   (cmd_ptr1),
        .misaligned (misaligned),
        .db_base    (db_base),
        .ei_base    (ei_base),
        .enabled    (shadow_enabled),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status)
    );

    // Gather both stored bases for the per-buffer generators.
    always_comb begin
        buf_base[0] = db_base;
        buf_base[1] = ei_base;
    end

    for (genvar k = 0; k < NBUF; k++) begin : g_buf
        sdb_slot_calc #(.ADDR_W(ADDR_W), .QID_W(QID_W), .SF_W(SF_W)) u_calc (
            .base         (buf_base[k]),
            .qid          (lk_qid),
            .stride_field (stride_field),
            .sq_addr      (raw_sq[k]),
            .cq_addr      (raw_cq[k])
        );
    end

    // Gate lookup results: only I/O queues of an enabled unit get addresses.
    always_comb begin
        lk_valid   = shadow_enabled && (lk_qid != '0);
        sq_db_addr = lk_valid ? raw_sq[0] : '0;
        cq_db_addr = lk_valid ? raw_cq[0] : '0;
        sq_ei_addr = lk_valid ? raw_sq[1] : '0;
        cq_ei_addr = lk_valid ? raw_cq[1] : '0;
    end

    // Advertise the feature in the identify capability word.
    always_comb begin
        oacs_caps          = '0;
        oacs_caps[CAP_BIT] = 1'b1;
    end

    // R6: completion slot is one stride above the submission slot
    assert_cq_one_stride_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ((cq_db_addr - sq_db_addr) == (ADDR_W'(4) << stride_field)));

    // R5: both buffers use the same offset from their own base
    assert_same_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ((sq_ei_addr - ei_base) == (sq_db_addr - db_base)));

    // R7: the admin queue never receives shadow addresses
    assert_admin_queue_excluded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_qid == '0) |-> (!lk_valid && sq_db_addr == '0 && cq_ei_addr == '0));

    // R8: nothing is produced while disabled
    assert_disabled_no_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !shadow_enabled |-> (!lk_valid && sq_ei_addr == '0 && cq_db_addr == '0));
endmodule

// File: tb/tb_shadow_db_setup.sv
`timescale 1ns/1ps
module tb_shadow_db_setup;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_reset = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_opcode = 8'h00;
    logic [63:0] cmd_ptr0 = '0;
    logic [63:0] cmd_ptr1 = '0;
    logic [5:0]  page_shift = 6'd12;
    logic [3:0]  stride_field = 4'd0;
    logic        rsp_valid;
    logic [15:0] rsp_status;
    logic        shadow_enabled;
    logic [15:0] oacs_caps;
    logic [15:0] lk_qid = '0;
    logic        lk_valid;
    logic [63:0] sq_db_addr, sq_ei_addr, cq_db_addr, cq_ei_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    shadow_db_setup dut (
        .clk(clk), .rst_n(rst_n), .ctrl_reset(ctrl_reset),
        .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_ptr0(cmd_ptr0), .cmd_ptr1(cmd_ptr1),
        .page_shift(page_shift), .stride_field(stride_field),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .shadow_enabled(shadow_enabled), .oacs_caps(oacs_caps),
        .lk_qid(lk_qid), .lk_valid(lk_valid),
        .sq_db_addr(sq_db_addr), .sq_ei_addr(sq_ei_addr),
        .cq_db_addr(cq_db_addr), .cq_ei_addr(cq_ei_addr)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Issue one command and check the response strobe and its width (R1).
    task automatic send_cmd(input string tag, input logic [7:0] opc, input logic [63:0] a,
                            input logic [63:0] b, input logic exp_rsp, input logic [15:0] exp_sts);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_opcode = opc; cmd_ptr0 = a; cmd_ptr1 = b;
        @(posedge clk); #1;
        check({tag, " R1 rsp_valid"}, 64'(rsp_valid), 64'(exp_rsp));
        if (exp_rsp) check({tag, " status"}, 64'(rsp_status), 64'(exp_sts));
        @(negedge clk);
        cmd_valid = 1'b0;
        @(posedge clk); #1;
        check({tag, " R1 strobe one cycle"}, 64'(rsp_valid), 64'd0);
    endtask

    // Look up a queue and compare all four addresses with the formula (R5, R6).
    task automatic lookup(input string tag, input logic [15:0] q, input logic [3:0] sf,
                          input logic [63:0] dbb, input logic [63:0] eib);
        logic [63:0] stride;
        logic        exp_v;
        @(negedge clk);
        lk_qid = q; stride_field = sf;
        #1;
        stride = 64'd4 << sf;
        exp_v  = (q != 0);
        check({tag, " lk_valid"}, 64'(lk_valid), 64'(exp_v));
        check({tag, " R5 sq_db"}, sq_db_addr, exp_v ? dbb + 64'(2 * q) * stride : 64'd0);
        check({tag, " R5 sq_ei"}, sq_ei_addr, exp_v ? eib + 64'(2 * q) * stride : 64'd0);
        check({tag, " R6 cq_db"}, cq_db_addr, exp_v ? dbb + 64'(2 * q + 1) * stride : 64'd0);
        check({tag, " R6 cq_ei"}, cq_ei_addr, exp_v ? eib + 64'(2 * q + 1) * stride : 64'd0);
    endtask

    task automatic expect_disabled(input string tag);
        @(negedge clk);
        lk_qid = 16'd3;
        #1;
        check({tag, " enabled"}, 64'(shadow_enabled), 64'd0);
        check({tag, " lk_valid"}, 64'(lk_valid), 64'd0);
        check({tag, " sq_db zero"}, sq_db_addr, 64'd0);
        check({tag, " cq_ei zero"}, cq_ei_addr, 64'd0);
    endtask

    task automatic t_reset_state;
        check("R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R10 caps", 64'(oacs_caps), 64'h0100);
        expect_disabled("R8 after reset");
    endtask

    task automatic t_rejects;
        page_shift = 6'd12;
        send_cmd("R3 ptr0 misaligned", 8'h7C, 64'h0000_0001_0000_0010, 64'h2000, 1'b1, 16'h4002);
        expect_disabled("R3 after ptr0 reject");
        send_cmd("R3 ptr1 misaligned", 8'h7C, 64'h1000, 64'h0000_0000_0000_2800, 1'b1, 16'h4002);
        expect_disabled("R3 after ptr1 reject");
        send_cmd("R1 other opcode", 8'h7D, 64'h1000, 64'h2000, 1'b0, 16'h0);
        expect_disabled("R1 other opcode no effect");
    endtask

    task automatic t_configure;
        page_shift = 6'd12;
        send_cmd("R2 aligned", 8'h7C, 64'h0000_0001_2345_6000, 64'h0000_0008_0000_0000, 1'b1, 16'h0000);
        check("R4 enabled", 64'(shadow_enabled), 64'd1);
        lookup("R5 q1 sf0", 16'd1, 4'd0, 64'h0000_0001_2345_6000, 64'h0000_0008_0000_0000);
        lookup("R6 q5 sf2", 16'd5, 4'd2, 64'h0000_0001_2345_6000, 64'h0000_0008_0000_0000);
        lookup("R7 admin q", 16'd0, 4'd1, 64'h0000_0001_2345_6000, 64'h0000_0008_0000_0000);
        lookup("R5 qmax sf15", 16'hFFFF, 4'd15, 64'h0000_0001_2345_6000, 64'h0000_0008_0000_0000);
        send_cmd("R3 reject while enabled", 8'h7C, 64'h0000_0000_0000_7004, 64'h9000, 1'b1, 16'h4002);
        lookup("R3 bases kept", 16'd2, 4'd0, 64'h0000_0001_2345_6000, 64'h0000_0008_0000_0000);
        page_shift = 6'd16;
        send_cmd("R2 aligned 64K", 8'h7C, 64'h0000_00AB_0001_0000, 64'h0000_00CD_0000_0000, 1'b1, 16'h0000);
        lookup("R4 replaced bases", 16'd7, 4'd3, 64'h0000_00AB_0001_0000, 64'h0000_00CD_0000_0000);
        send_cmd("R2 64K misaligned", 8'h7C, 64'h0000_00AB_0000_8000, 64'h0, 1'b1, 16'h4002);
    endtask

    task automatic t_ctrl_reset;
        @(negedge clk);
        ctrl_reset = 1'b1; cmd_valid = 1'b1; cmd_opcode = 8'h7C;
        cmd_ptr0 = 64'h0004_0000; cmd_ptr1 = 64'h0008_0000;
        @(posedge clk); #1;
        check("R9 command dropped", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        ctrl_reset = 1'b0; cmd_valid = 1'b0;
        expect_disabled("R9 after ctrl reset");
    endtask

    task automatic t_sync_reset;
        page_shift = 6'd12;
        send_cmd("R2 before reset", 8'h7C, 64'h5000, 64'h6000, 1'b1, 16'h0000);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R11 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        expect_disabled("R11 after rst_n");
        check("R10 caps steady", 64'(oacs_caps), 64'h0100);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_rejects();
        t_configure();
        t_ctrl_reset();
        t_sync_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule